// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the execution core and owns the processor status word (PSW) and the stack pointer. At every instruction boundary it looks at the interrupt request lines. Each line has an enable, a 3-bit priority and a vector. The block takes a request only when the request outranks the program that is running. It then runs the hardware part of the entry: it moves from the user stack to the supervisor stack when needed, and pushes the old status word and the return PC through a single-port memory interface. It raises the processor to supervisor mode at the device's priority, with the condition codes cleared, and reads the handler address from the vector table. The core loads that address when `pc_load` pulses.

A return request undoes the entry. The block pops the PC and then the status word. If the restored mode is user, it also parks the supervisor stack pointer and brings back the user stack pointer. While a sequence runs, `busy` is high. The core holds off instruction completion during that time, and the block ignores new requests.

PSW layout: bit 15 is the mode (1 = user, 0 = supervisor), bits 10:8 hold the program priority, and bits 2:0 hold the condition codes N, Z, P. All other bits are zero. After reset the PSW is 0x8000 and the stack pointer equals `USP_INIT`. The saved supervisor pointer starts at `SSP_INIT`.

Top module: `irq_ctx_seq`

## Requirements
- R1: An interrupt is taken in a cycle only when the block is idle, `instr_done` is high, and `rti_req` is not being honoured. The winning line must also have both request and enable set and a priority strictly greater than PSW[10:8]. When an interrupt is taken, `irq_ack` pulses for that cycle.
- R2: Among the lines that are requesting and enabled, the highest priority wins. On equal priority the lowest index wins. `irq_ack` is never more than one-hot.
- R3: If PSW[15] is 1 when an interrupt is taken, the stack pointer is saved to user storage and replaced by the saved supervisor pointer. If PSW[15] is 0, the stack pointer is kept.
- R4: In the first cycle after the interrupt is taken, the old PSW is written to address SP-1. In the second cycle, the PC sampled at acceptance is written to the next lower address. Each write decrements SP by one.
- R5: From the cycle after acceptance, the PSW reads mode 0, priority equal to the device priority, and condition codes 000.
- R6: In the third cycle after acceptance, the block reads the vector address. In the fourth cycle, `pc_load` is high and `new_pc` carries the word read.
- R7: A return request, taken at `instr_done` in supervisor mode while idle, produces two reads. The first reads at SP and gives the PC. The second reads at SP+1 and gives the PSW. SP rises by one after each read. In the third cycle after the request, `pc_load` is high with the popped PC, and the popped PSW is in place from the next cycle.
- R8: If the restored PSW has mode 1, the supervisor SP is saved and the user SP is restored. Otherwise SP stays at the popped position.
- R9: A return request made in user mode is ignored. Request lines and `instr_done` are ignored while `busy` is high.
- R10: When the block is idle and neither an interrupt nor a return is taken, `cc_we` writes `cc_in` into PSW[2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N | Request per line |
| irq_en | input | N | Enable per line |
| irq_pri | input | 3*N | Priority per line, line i at [3i+2:3i] |
| irq_vec | input | W*N | Vector-table address per line, line i at [Wi+W-1:Wi] |
| instr_done | input | 1 | Current instruction has completed |
| rti_req | input | 1 | Return-from-interrupt request |
| cur_pc | input | W | PC to save on entry |
| cc_we | input | 1 | Condition-code write strobe |
| cc_in | input | 3 | Condition codes N, Z, P |
| irq_ack | output | N | One-hot accept pulse |
| busy | output | 1 | Sequence in progress |
| psw | output | 16 | Processor status word |
| sp | output | W | Current stack pointer |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | W | Memory address |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Read data, valid the cycle after `mem_re` |
| pc_load | output | 1 | Load `new_pc` into the core PC |
| new_pc | output | W | Handler or return address |

## Verification
Results fall due at fixed offsets from the cycle in which a request is taken. The acknowledge appears in that same cycle. The new PSW and the swapped stack pointer show one cycle later. The two pushes come one and two cycles later, the vector read three cycles later, and `pc_load` four cycles later. For a return, the two pops come one and two cycles later, `pc_load` three cycles later, and the restored PSW and SP four cycles later. The bench keeps a behavioural model that steps through those offsets with a phase counter and its own copy of memory. It compares every output against the model at each falling edge, so a result that arrives one cycle early or late fails in the cycle where it should have appeared.

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq #(
  parameter int N = 4,
  parameter int W = 16,
  parameter logic [W-1:0] USP_INIT = 16'h0080,
  parameter logic [W-1:0] SSP_INIT = 16'h00F0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   irq_req,
  input  logic [N-1:0]   irq_en,
  input  logic [3*N-1:0] irq_pri,
  input  logic [W*N-1:0] irq_vec,
  input  logic           instr_done,
  input  logic           rti_req,
  input  logic [W-1:0]   cur_pc,
  input  logic           cc_we,
  input  logic [2:0]     cc_in,
  output logic [N-1:0]   irq_ack,
  output logic           busy,
  output logic [15:0]    psw,
  output logic [W-1:0]   sp,
  output logic           mem_we,
  output logic           mem_re,
  output logic [W-1:0]   mem_addr,
  output logic [W-1:0]   mem_wdata,
  input  logic [W-1:0]   mem_rdata,
  output logic           pc_load,
  output logic [W-1:0]   new_pc
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_PPSR, S_PPC, S_VRD, S_VWT, S_POP1, S_POP2, S_REND
  } st_t;

  st_t          st;
  logic [15:0]  psw_q, sv_psr;
  logic [W-1:0] sp_q, usp_q, ssp_q, sv_pc, vec_q, rpc_q;

  logic          win_v;
  logic [IW-1:0] win_idx;
  logic [2:0]    win_pri;

  always_comb begin
    win_v = 1'b0;
    win_idx = '0;
    win_pri = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (irq_req[i] && irq_en[i] && (!win_v || irq_pri[3*i +: 3] >= win_pri)) begin
        win_v = 1'b1;
        win_idx = IW'(i);
        win_pri = irq_pri[3*i +: 3];
      end
    end
  end

  wire idle   = (st == S_IDLE);
  wire rti_go = idle && instr_done && rti_req && !psw_q[15];
  wire take   = idle && instr_done && !rti_go && win_v && (win_pri > psw_q[10:8]);

  assign irq_ack   = take ? (N'(1) << win_idx) : '0;
  assign busy      = !idle;
  assign psw       = psw_q;
  assign sp        = sp_q;
  assign mem_we    = (st == S_PPSR) || (st == S_PPC);
  assign mem_re    = (st == S_VRD) || (st == S_POP1) || (st == S_POP2);
  assign mem_addr  = mem_we ? sp_q - 1'b1 : (st == S_VRD) ? vec_q : mem_re ? sp_q : '0;
  assign mem_wdata = (st == S_PPSR) ? W'(sv_psr) : (st == S_PPC) ? sv_pc : '0;
  assign pc_load   = (st == S_VWT) || (st == S_REND);
  assign new_pc    = (st == S_VWT) ? mem_rdata : (st == S_REND) ? rpc_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      psw_q <= 16'h8000;
      sp_q <= USP_INIT;
      usp_q <= '0;
      ssp_q <= SSP_INIT;
      sv_psr <= '0;
      sv_pc <= '0;
      vec_q <= '0;
      rpc_q <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (rti_go) begin
            st <= S_POP1;
          end else if (take) begin
            sv_psr <= psw_q;
            sv_pc <= cur_pc;
            vec_q <= irq_vec[W*win_idx +: W];
            if (psw_q[15]) begin
              usp_q <= sp_q;
              sp_q <= ssp_q;
            end
            psw_q <= {1'b0, psw_q[14:11], win_pri, psw_q[7:3], 3'b000};
            st <= S_PPSR;
          end else if (cc_we) begin
            psw_q[2:0] <= cc_in;
          end
        end
        S_PPSR: begin sp_q <= sp_q - 1'b1; st <= S_PPC; end
        S_PPC:  begin sp_q <= sp_q - 1'b1; st <= S_VRD; end
        S_VRD:  st <= S_VWT;
        S_VWT:  st <= S_IDLE;
        S_POP1: begin sp_q <= sp_q + 1'b1; st <= S_POP2; end
        S_POP2: begin sp_q <= sp_q + 1'b1; rpc_q <= mem_rdata; st <= S_REND; end
        S_REND: begin
          psw_q <= mem_rdata[15:0];
          if (mem_rdata[15]) begin
            ssp_q <= sp_q;
            sp_q <= usp_q;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(irq_ack));
  // R1
  ack_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> (instr_done && !busy && win_pri > psw[10:8]));
  // R5
  entry_psw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |=> (!psw[15] && psw[2:0] == 3'b000 && psw[10:8] == $past(win_pri)));
  // R4
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp == $past(sp) - 1'b1));
  // R7
  pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POP1) |=> (sp == $past(sp) + 1'b1 && mem_re));
  // R9
  user_rti_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rti_req && instr_done && psw[15] && !(|irq_ack)) |=> !busy);
endmodule

// File: tb/tb_irq_ctx_seq.sv
module tb_irq_ctx_seq;
  localparam int N = 4;
  localparam int W = 16;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = '0, en = '0;
  logic [3*N-1:0] pri = '0;
  logic [W*N-1:0] vec;
  logic instr_done = 0, rti_req = 0, cc_we = 0;
  logic [W-1:0] cur_pc = '0;
  logic [2:0] cc_in = '0;
  logic [N-1:0] ack;
  logic busy, mem_we, mem_re, pc_load;
  logic [15:0] psw;
  logic [W-1:0] sp, mem_addr, mem_wdata, new_pc;
  logic [W-1:0] mem_rdata = '0;
  logic [15:0] mem [256];

  int tests = 0, fails = 0, cyc = 0;
  bit live = 0;

  always #10 clk = ~clk;

  irq_ctx_seq dut (
    .clk(clk), .rst_n(rst_n), .irq_req(req), .irq_en(en), .irq_pri(pri), .irq_vec(vec),
    .instr_done(instr_done), .rti_req(rti_req), .cur_pc(cur_pc), .cc_we(cc_we), .cc_in(cc_in),
    .irq_ack(ack), .busy(busy), .psw(psw), .sp(sp), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pc_load(pc_load), .new_pc(new_pc));

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // reference model
  int ph = 0;
  logic [15:0] m_psw = 16'h8000, sv_psr, r_psr;
  logic [15:0] m_sp = 16'h0080, m_usp = 0, m_ssp = 16'h00F0, sv_pc, m_vec, r_pc;
  logic [15:0] m_mem [256];

  always @(negedge clk) begin
    int e_ack, best;
    logic [2:0] bp;
    bit e_we, e_re, e_pl, took;
    logic [15:0] e_addr, e_data, e_pc;
    cyc++;
    if (cyc > 5000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected <5000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    if (live) begin
      e_ack = 0; e_we = 0; e_re = 0; e_pl = 0; e_addr = 0; e_data = 0; e_pc = 0; took = 0;
      chk("R5", "psw", psw, m_psw);
      chk("R3", "sp", sp, m_sp);
      chk("R9", "busy", busy, ph != 0);
      case (ph)
        0: begin
          if (instr_done && rti_req && !m_psw[15]) ph = 10;
          else if (instr_done) begin
            best = -1; bp = 0;
            for (int i = 0; i < N; i++)
              if (req[i] && en[i] && (best < 0 || pri[3*i +: 3] > bp)) begin
                best = i; bp = pri[3*i +: 3];
              end
            if (best >= 0 && bp > m_psw[10:8]) begin
              took = 1; e_ack = 1 << best;
              sv_psr = m_psw; sv_pc = cur_pc; m_vec = vec[16*best +: 16];
              if (m_psw[15]) begin m_usp = m_sp; m_sp = m_ssp; end
              m_psw[15] = 0; m_psw[10:8] = bp; m_psw[2:0] = 0;
              ph = 1;
            end
          end
          if (ph == 0 && !took && cc_we) m_psw[2:0] = cc_in; // R10
        end
        1, 2: begin
          e_we = 1; m_sp = m_sp - 1; e_addr = m_sp;
          e_data = (ph == 1) ? sv_psr : sv_pc;
          m_mem[m_sp[7:0]] = e_data;
          ph++;
        end
        3: begin e_re = 1; e_addr = m_vec; ph = 4; end
        4: begin e_pl = 1; e_pc = m_mem[m_vec[7:0]]; ph = 0; end
        10: begin e_re = 1; e_addr = m_sp; r_pc = m_mem[m_sp[7:0]]; m_sp++; ph = 11; end
        11: begin e_re = 1; e_addr = m_sp; r_psr = m_mem[m_sp[7:0]]; m_sp++; ph = 12; end
        12: begin
          e_pl = 1; e_pc = r_pc; m_psw = r_psr;
          if (r_psr[15]) begin m_ssp = m_sp; m_sp = m_usp; end // R8
          ph = 0;
        end
        default: ph = 0;
      endcase
      chk("R2", "irq_ack", ack, e_ack);
      chk("R4", "mem_we", mem_we, e_we);
      chk("R7", "mem_re", mem_re, e_re);
      if (e_we || e_re) chk("R4", "mem_addr", mem_addr, e_addr);
      if (e_we) chk("R4", "mem_wdata", mem_wdata, e_data);
      chk("R6", "pc_load", pc_load, e_pl);
      if (e_pl) chk("R6", "new_pc", new_pc, e_pc);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic boundary();
    instr_done = 1; step(1); instr_done = 0;
  endtask

  task automatic set_line(int i, bit r, bit e, int p);
    req[i] = r; en[i] = e; pri[3*i +: 3] = 3'(p);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 16'h0; m_mem[i] = 16'h0; end
    for (int i = 0; i < N; i++) begin
      vec[16*i +: 16] = 16'(16'h0010 + i);
      mem[16 + i] = 16'(16'h0400 + 16'h0100 * i);
      m_mem[16 + i] = 16'(16'h0400 + 16'h0100 * i);
    end
    step(3);
    chk("R5", "reset psw", psw, 16'h8000);
    chk("R3", "reset sp", sp, 16'h0080);
    chk("R9", "reset busy", busy, 0);
    rst_n = 1; live = 1;
    step(1);
    // R10: condition codes written while idle
    cc_in = 3'b010; cc_we = 1; step(1); cc_we = 0;
    // R1: pending request waits for the instruction boundary
    set_line(1, 1, 1, 3); cur_pc = 16'h1234;
    step(3);
    boundary();
    // R9: requests while busy are ignored
    set_line(2, 1, 1, 7); instr_done = 1; step(3); instr_done = 0;
    set_line(2, 0, 0, 0); set_line(1, 0, 1, 3);
    step(4);
    // R1: equal priority not taken; disabled higher line ignored
    set_line(0, 1, 1, 3); set_line(3, 1, 0, 6); cur_pc = 16'h2000;
    boundary(); step(2);
    // R2, R3: tie at priority 5 -> lowest index, nested entry keeps SP
    set_line(0, 0, 0, 0); set_line(3, 0, 0, 0);
    set_line(1, 1, 1, 5); set_line(2, 1, 1, 5); cur_pc = 16'h2222;
    boundary(); set_line(1, 0, 0, 0); set_line(2, 0, 0, 0);
    step(6);
    // R7, R8: return to priority 3 supervisor, then to user
    rti_req = 1; boundary(); rti_req = 0; step(6);
    cc_in = 3'b100; cc_we = 1; step(1); cc_we = 0;
    rti_req = 1; boundary(); rti_req = 0; step(6);
    // R9: return request in user mode ignored
    rti_req = 1; boundary(); rti_req = 0; step(3);
    // R3: fresh entry from user with lowest nonzero priority
    set_line(3, 1, 1, 1); cur_pc = 16'h3333;
    boundary(); set_line(3, 0, 0, 0); step(6);
    rti_req = 1; boundary(); rti_req = 0; step(6);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule